// File: doc/BRIEF.md
# Ring Occupancy and Index Tracker

This block keeps the per-ring counters for a small set of descriptor rings that software and a DMA engine share. For every ring it holds a 48-bit base address, a programmed element count, an element-size code, an event number and an order-ID override. It also holds two occupancy counters and two read indices. Software announces new work with a doorbell that carries a signed 8-bit delta. The DMA engine reports each finished entry on a completion port. Software retires entries it has handled on a retire strobe.

Each completion takes one entry off the software occupancy and adds one to the hardware occupancy. It also advances the hardware index. A retire takes one entry off the hardware occupancy and advances the software index. Each index wraps at the programmed element count. That count does not have to be a power of two.

A completion produces a response beat one cycle later. The beat carries the address of the entry being completed, the order ID to use and the ring's event number. The response is a valid/ready stream. While a beat is held and `rsp_ready` is low, `cmp_ready` is low, so no completion is lost. The doorbell stream never stalls: `db_ready` is always high. A combinational lookup port exposes one ring's counters, indices and software-side element address.

Top module: `ring_tracker`

## Requirements
- R1: After reset, every ring has both occupancies at 0 and both indices at 0. Its event number is 0xFFFF, its error flag is clear and `rsp_valid` is low.
- R2: An accepted doorbell adds `db_delta`, read as 8-bit two's complement, to the ring's 21-bit software occupancy.
- R3: A completion subtracts 1 from that ring's software occupancy and adds 1 to its hardware occupancy. A retire subtracts 1 from the hardware occupancy. Operations that hit the same ring in the same cycle are summed.
- R4: Both occupancies saturate at 0 and at 2^21-1. Any clamped step sets the ring's error flag, and the flag stays set until reset.
- R5: A completion advances the hardware index and a retire advances the software index. The index becomes index+1 (20-bit), or 0 when index+1 equals the programmed element count.
- R6: An element address is base + (index << (code+2)), taken to 48 bits. Code 0..6 selects 4..256-byte elements, and code 7 is treated like 6. The response carries the address of the hardware index before it advances. `look_sw_addr` uses the software index.
- R7: If the ring's replace bit is 0, `rsp_oid` equals the incoming `cmp_oid`. If it is 1, `rsp_oid` equals the programmed 4-bit value.
- R8: `rsp_event` equals the ring's 16-bit event number.
- R9: A geometry write resets that ring's two indices and two occupancies to 0 on the same edge. It overrides any operation on that ring in that cycle and leaves other rings untouched.
- R10: A completion is accepted only when `cmp_valid` and `cmp_ready` are both high. A held response keeps its fields stable until `rsp_ready` is high.
- R11: The configuration selectors are 0 = base low word (data[31:0]) and 1 = base high word (data[15:0]). Selector 2 = geometry: count in data[19:0], code in data[30:28]. Selector 3 = event (data[15:0]). Selector 4 = order ID: value in data[3:0], replace bit in data[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | 2 | Ring addressed by the configuration write |
| cfg_sel | input | 3 | Configuration selector (R11) |
| cfg_wdata | input | 32 | Configuration write data |
| db_valid | input | 1 | Doorbell valid |
| db_ready | output | 1 | Doorbell ready, always high |
| db_ring | input | 2 | Doorbell ring |
| db_delta | input | 8 | Signed occupancy delta |
| cmp_valid | input | 1 | Completion valid |
| cmp_ready | output | 1 | Completion ready |
| cmp_ring | input | 2 | Completing ring |
| cmp_oid | input | 4 | Incoming order ID |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_ring | output | 2 | Ring of the response |
| rsp_addr | output | 48 | Address of the completed entry |
| rsp_oid | output | 4 | Order ID to use |
| rsp_event | output | 16 | Ring event number |
| ret_valid | input | 1 | Software retire strobe |
| ret_ring | input | 2 | Retired ring |
| look_ring | input | 2 | Ring selected for the lookup |
| look_sw_occ | output | 21 | Software occupancy |
| look_hw_occ | output | 21 | Hardware occupancy |
| look_sw_idx | output | 20 | Software index |
| look_hw_idx | output | 20 | Hardware index |
| look_sw_addr | output | 48 | Element address at the software index |
| err | output | 4 | Sticky per-ring error flags |

## Verification
The bench drives the counters against both saturation limits. It pumps one ring with +127 doorbells until it clamps, and it sends -128 doorbells and completions to empty rings. A design that wrapped instead of clamping would show a small count, or a count near the maximum, and would leave the error flag clear. Small random element counts force frequent non-power-of-two wraps; an index that wrapped one step late or early would shift every response address.

Geometry writes are issued in the same cycle as operations on the same ring, which exposes a design that lets the operation win over the reset. Random stalls on `rsp_ready` show whether a completion is dropped or taken twice while a beat is held. Code 7 and a base address whose low word carries into the high word check the shift clamp and the 48-bit add.

// File: rtl/ringtrk_pkg.sv
package ringtrk_pkg;

  typedef enum logic [2:0] {
    CFG_BASE_LO = 3'd0,
    CFG_BASE_HI = 3'd1,
    CFG_GEOM    = 3'd2,
    CFG_EVENT   = 3'd3,
    CFG_ORDER   = 3'd4
  } cfg_sel_e;

  // byte shift for an element-size code; the reserved code clamps to 256 bytes
  function automatic logic [3:0] esz_shift(input logic [2:0] code);
    return (code == 3'd7) ? 4'd8 : ({1'b0, code} + 4'd2);
  endfunction

endpackage

// File: rtl/ringtrk_occ.sv
module ringtrk_occ #(
  parameter int W  = 21,
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [DW-1:0] delta,
  output logic [W-1:0]         occ,
  output logic                 bad
);
  localparam int SW = W + 2;

  logic signed [SW-1:0] sum;
  logic [W-1:0]         nxt;

  always_comb begin
    sum = $signed({2'b00, occ}) + $signed({{(SW-DW){delta[DW-1]}}, delta});
    nxt = sum[W-1:0];
    bad = 1'b0;
    if (sum < 0) begin
      nxt = '0;
      bad = 1'b1;
    end else if (sum > $signed({2'b00, {W{1'b1}}})) begin
      nxt = '1;
      bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   occ <= '0;
    else if (clr) occ <= '0;
    else          occ <= nxt;
  end

  AST_OCC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && delta == '0) |=> $stable(occ)); // R3

endmodule

// File: rtl/ringtrk_idx.sv
module ringtrk_idx #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] size,
  output logic [W-1:0] idx
);
  logic [W-1:0] inc;

  assign inc = idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= (inc == size) ? '0 : inc;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (size != '0) |-> (idx < size)); // R5

endmodule

// File: rtl/ringtrk_agen.sv
module ringtrk_agen #(
  parameter int AW = 48,
  parameter int IW = 20
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] idx,
  input  logic [2:0]    code,
  output logic [AW-1:0] addr
);
  import ringtrk_pkg::*;

  logic [AW-1:0] off;

  assign off  = {{(AW-IW){1'b0}}, idx} << esz_shift(code);
  assign addr = base + off;

endmodule

// File: rtl/ringtrk_ring.sv
module ringtrk_ring #(
  parameter int AW    = 48,
  parameter int IDX_W = 20,
  parameter int OCC_W = 21,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hit,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             db_hit,
  input  logic [DB_W-1:0]  db_delta,
  input  logic             cmp_hit,
  input  logic             ret_hit,
  output logic [AW-1:0]    base,
  output logic [2:0]       esz,
  output logic [15:0]      evnum,
  output logic [3:0]       oid,
  output logic             oid_rep,
  output logic [OCC_W-1:0] sw_occ,
  output logic [OCC_W-1:0] hw_occ,
  output logic [IDX_W-1:0] sw_idx,
  output logic [IDX_W-1:0] hw_idx,
  output logic             err
);
  import ringtrk_pkg::*;

  localparam int HI_W = AW - 32;
  localparam int DW   = DB_W + 2;

  cfg_sel_e          sel;
  logic              geom_wr;
  logic [IDX_W-1:0]  size;
  logic signed [DW-1:0] sw_d, hw_d;
  logic              sw_bad, hw_bad;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign geom_wr = cfg_hit && (sel == CFG_GEOM);

  always_comb begin
    sw_d = db_hit ? DW'($signed(db_delta)) : '0;
    if (cmp_hit) sw_d = sw_d - DW'(1);
    hw_d = '0;
    if (cmp_hit) hw_d = hw_d + DW'(1);
    if (ret_hit) hw_d = hw_d - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      size    <= '0;
      esz     <= '0;
      evnum   <= 16'hFFFF;
      oid     <= '0;
      oid_rep <= 1'b0;
    end else if (cfg_hit) begin
      case (sel)
        CFG_BASE_LO: base[31:0]  <= cfg_wdata;
        CFG_BASE_HI: base[AW-1:32] <= cfg_wdata[HI_W-1:0];
        CFG_GEOM: begin
          size <= cfg_wdata[IDX_W-1:0];
          esz  <= cfg_wdata[30:28];
        end
        CFG_EVENT:   evnum <= cfg_wdata[15:0];
        CFG_ORDER: begin
          oid     <= cfg_wdata[3:0];
          oid_rep <= cfg_wdata[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err <= 1'b0;
    else if (!geom_wr) err <= err | sw_bad | hw_bad;
  end

  ringtrk_occ #(.W(OCC_W), .DW(DW)) u_sw_occ (
    .clk(clk), .rst_n(rst_n), .clr(geom_wr), .delta(sw_d), .occ(sw_occ), .bad(sw_bad));
  ringtrk_occ #(.W(OCC_W), .DW(DW)) u_hw_occ (
    .clk(clk), .rst_n(rst_n), .clr(geom_wr), .delta(hw_d), .occ(hw_occ), .bad(hw_bad));
  ringtrk_idx #(.W(IDX_W)) u_sw_idx (
    .clk(clk), .rst_n(rst_n), .clr(geom_wr), .adv(ret_hit), .size(size), .idx(sw_idx));
  ringtrk_idx #(.W(IDX_W)) u_hw_idx (
    .clk(clk), .rst_n(rst_n), .clr(geom_wr), .adv(cmp_hit), .size(size), .idx(hw_idx));

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R4
  AST_GEOM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    geom_wr |=> (sw_occ == '0 && hw_occ == '0 && sw_idx == '0 && hw_idx == '0)); // R9

endmodule

// File: rtl/ring_tracker.sv
module ring_tracker #(
  parameter int NRING = 4,
  parameter int AW    = 48,
  parameter int IDX_W = 20,
  parameter int OCC_W = 21,
  parameter int DB_W  = 8,
  localparam int RW   = (NRING > 1) ? $clog2(NRING) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RW-1:0]    cfg_ring,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             db_valid,
  output logic             db_ready,
  input  logic [RW-1:0]    db_ring,
  input  logic [DB_W-1:0]  db_delta,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic [RW-1:0]    cmp_ring,
  input  logic [3:0]       cmp_oid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RW-1:0]    rsp_ring,
  output logic [AW-1:0]    rsp_addr,
  output logic [3:0]       rsp_oid,
  output logic [15:0]      rsp_event,
  input  logic             ret_valid,
  input  logic [RW-1:0]    ret_ring,
  input  logic [RW-1:0]    look_ring,
  output logic [OCC_W-1:0] look_sw_occ,
  output logic [OCC_W-1:0] look_hw_occ,
  output logic [IDX_W-1:0] look_sw_idx,
  output logic [IDX_W-1:0] look_hw_idx,
  output logic [AW-1:0]    look_sw_addr,
  output logic [NRING-1:0] err
);
  logic [AW-1:0]    base_a   [NRING];
  logic [2:0]       esz_a    [NRING];
  logic [15:0]      ev_a     [NRING];
  logic [3:0]       oid_a    [NRING];
  logic [NRING-1:0] rep_a;
  logic [OCC_W-1:0] swocc_a  [NRING];
  logic [OCC_W-1:0] hwocc_a  [NRING];
  logic [IDX_W-1:0] swidx_a  [NRING];
  logic [IDX_W-1:0] hwidx_a  [NRING];

  logic          cmp_fire;
  logic [AW-1:0] cmp_addr;

  assign db_ready  = 1'b1;
  assign cmp_ready = !rsp_valid || rsp_ready;
  assign cmp_fire  = cmp_valid && cmp_ready;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ringtrk_ring #(.AW(AW), .IDX_W(IDX_W), .OCC_W(OCC_W), .DB_W(DB_W)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (cfg_we && cfg_ring == RW'(g)),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .db_hit   (db_valid && db_ring == RW'(g)),
      .db_delta (db_delta),
      .cmp_hit  (cmp_fire && cmp_ring == RW'(g)),
      .ret_hit  (ret_valid && ret_ring == RW'(g)),
      .base     (base_a[g]),
      .esz      (esz_a[g]),
      .evnum    (ev_a[g]),
      .oid      (oid_a[g]),
      .oid_rep  (rep_a[g]),
      .sw_occ   (swocc_a[g]),
      .hw_occ   (hwocc_a[g]),
      .sw_idx   (swidx_a[g]),
      .hw_idx   (hwidx_a[g]),
      .err      (err[g])
    );
  end

  ringtrk_agen #(.AW(AW), .IW(IDX_W)) u_agen_cmp (
    .base(base_a[cmp_ring]), .idx(hwidx_a[cmp_ring]), .code(esz_a[cmp_ring]), .addr(cmp_addr));
  ringtrk_agen #(.AW(AW), .IW(IDX_W)) u_agen_look (
    .base(base_a[look_ring]), .idx(swidx_a[look_ring]), .code(esz_a[look_ring]), .addr(look_sw_addr));

  assign look_sw_occ = swocc_a[look_ring];
  assign look_hw_occ = hwocc_a[look_ring];
  assign look_sw_idx = swidx_a[look_ring];
  assign look_hw_idx = hwidx_a[look_ring];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ring  <= '0;
      rsp_addr  <= '0;
      rsp_oid   <= '0;
      rsp_event <= '0;
    end else if (cmp_fire) begin
      rsp_valid <= 1'b1;
      rsp_ring  <= cmp_ring;
      rsp_addr  <= cmp_addr;
      rsp_oid   <= rep_a[cmp_ring] ? oid_a[cmp_ring] : cmp_oid;
      rsp_event <= ev_a[cmp_ring];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_oid)
                                   && $stable(rsp_event) && $stable(rsp_ring))); // R10
  AST_DB_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> db_ready); // R2

endmodule

// File: tb/ring_tracker_test.sv
`timescale 1ns/1ps
module ring_tracker_test;
  localparam int NR = 4;
  localparam longint AMASK = 64'hFFFF_FFFF_FFFF;
  localparam longint OMAX  = (64'd1 << 21) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_ring = 0; logic [2:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic db_valid = 0; logic db_ready; logic [1:0] db_ring = 0; logic [7:0] db_delta = 0;
  logic cmp_valid = 0; logic cmp_ready; logic [1:0] cmp_ring = 0; logic [3:0] cmp_oid = 0;
  logic rsp_valid; logic rsp_ready = 1; logic [1:0] rsp_ring; logic [47:0] rsp_addr;
  logic [3:0] rsp_oid; logic [15:0] rsp_event;
  logic ret_valid = 0; logic [1:0] ret_ring = 0; logic [1:0] look_ring = 0;
  logic [20:0] look_sw_occ, look_hw_occ; logic [19:0] look_sw_idx, look_hw_idx;
  logic [47:0] look_sw_addr; logic [3:0] err;

  // stimulus staged by the tests, applied at the falling edge
  logic s_cfg_we = 0; logic [1:0] s_cfg_ring = 0; logic [2:0] s_cfg_sel = 0; logic [31:0] s_cfg_wdata = 0;
  logic s_db_valid = 0; logic [1:0] s_db_ring = 0; logic [7:0] s_db_delta = 0;
  logic s_cmp_valid = 0; logic [1:0] s_cmp_ring = 0; logic [3:0] s_cmp_oid = 0;
  logic s_rsp_ready = 1; logic s_ret_valid = 0; logic [1:0] s_ret_ring = 0; logic [1:0] s_look = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  longint m_base[NR], m_size[NR], m_esz[NR], m_ev[NR], m_oid[NR], m_so[NR], m_ho[NR], m_si[NR], m_hi[NR];
  bit m_rep[NR], m_err[NR];
  bit e_valid = 0; longint e_addr = 0, e_oid = 0, e_ev = 0, e_ring = 0;

  ring_tracker uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint addr_of(input int k, input longint idx);
    longint sh = (m_esz[k] == 7) ? 8 : m_esz[k] + 2;
    return (m_base[k] + (idx << sh)) & AMASK;
  endfunction

  function automatic longint adv(input longint idx, input longint size);
    longint n = (idx + 1) & 64'hFFFFF;
    return (n == size) ? 0 : n;
  endfunction

  task automatic tick();
    bit fire;
    @(negedge clk);
    cfg_we = s_cfg_we; cfg_ring = s_cfg_ring; cfg_sel = s_cfg_sel; cfg_wdata = s_cfg_wdata;
    db_valid = s_db_valid; db_ring = s_db_ring; db_delta = s_db_delta;
    cmp_valid = s_cmp_valid; cmp_ring = s_cmp_ring; cmp_oid = s_cmp_oid;
    rsp_ready = s_rsp_ready; ret_valid = s_ret_valid; ret_ring = s_ret_ring; look_ring = s_look;
    #1;
    fire = cmp_valid && cmp_ready;
    if (fire) begin
      e_valid = 1; e_ring = cmp_ring; e_addr = addr_of(cmp_ring, m_hi[cmp_ring]);
      e_oid = m_rep[cmp_ring] ? m_oid[cmp_ring] : cmp_oid; e_ev = m_ev[cmp_ring];
    end else if (rsp_ready) e_valid = 0;
    for (int k = 0; k < NR; k++) begin
      bit hc = fire && cmp_ring == k;
      bit hr = ret_valid && ret_ring == k;
      longint d;
      if (cfg_we && cfg_ring == k) begin
        case (cfg_sel)
          3'd0: m_base[k] = (m_base[k] & 64'hFFFF_0000_0000) | cfg_wdata;
          3'd1: m_base[k] = (m_base[k] & 64'hFFFF_FFFF) | (longint'(cfg_wdata[15:0]) << 32);
          3'd3: m_ev[k] = cfg_wdata[15:0];
          3'd4: begin m_oid[k] = cfg_wdata[3:0]; m_rep[k] = cfg_wdata[4]; end
          default: ;
        endcase
        if (cfg_sel == 3'd2) begin
          m_size[k] = cfg_wdata[19:0]; m_esz[k] = cfg_wdata[30:28];
          m_so[k] = 0; m_ho[k] = 0; m_si[k] = 0; m_hi[k] = 0;
          continue;
        end
      end
      d = ((db_valid && db_ring == k) ? longint'($signed(db_delta)) : 0) - (hc ? 1 : 0);
      m_so[k] += d;
      if (m_so[k] < 0) begin m_so[k] = 0; m_err[k] = 1; end
      if (m_so[k] > OMAX) begin m_so[k] = OMAX; m_err[k] = 1; end
      m_ho[k] += (hc ? 1 : 0) - (hr ? 1 : 0);
      if (m_ho[k] < 0) begin m_ho[k] = 0; m_err[k] = 1; end
      if (m_ho[k] > OMAX) begin m_ho[k] = OMAX; m_err[k] = 1; end
      if (hc) m_hi[k] = adv(m_hi[k], m_size[k]);
      if (hr) m_si[k] = adv(m_si[k], m_size[k]);
    end
    @(posedge clk); #2;
    chk(look_sw_occ == m_so[look_ring], "R2 sw occupancy", look_sw_occ, m_so[look_ring]);
    chk(look_hw_occ == m_ho[look_ring], "R3 hw occupancy", look_hw_occ, m_ho[look_ring]);
    chk(look_sw_idx == m_si[look_ring], "R5 sw index", look_sw_idx, m_si[look_ring]);
    chk(look_hw_idx == m_hi[look_ring], "R5 hw index", look_hw_idx, m_hi[look_ring]);
    chk(look_sw_addr == addr_of(look_ring, m_si[look_ring]), "R6 lookup address",
        look_sw_addr, addr_of(look_ring, m_si[look_ring]));
    chk(err == {m_err[3], m_err[2], m_err[1], m_err[0]}, "R4 error flags", err,
        {m_err[3], m_err[2], m_err[1], m_err[0]});
    chk(rsp_valid == e_valid, "R10 response valid", rsp_valid, e_valid);
    if (e_valid) begin
      chk(rsp_addr == e_addr && rsp_ring == e_ring, "R6 response address", rsp_addr, e_addr);
      chk(rsp_oid == e_oid, "R7 order id", rsp_oid, e_oid);
      chk(rsp_event == e_ev, "R8 event number", rsp_event, e_ev);
    end
  endtask

  task automatic idle();
    s_cfg_we = 0; s_db_valid = 0; s_cmp_valid = 0; s_ret_valid = 0; s_rsp_ready = 1;
  endtask

  task automatic cfg(input int r, input int sel, input logic [31:0] d);
    idle(); s_cfg_we = 1; s_cfg_ring = 2'(r); s_cfg_sel = 3'(sel); s_cfg_wdata = d; tick(); idle();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd1234);
    for (int k = 0; k < NR; k++) begin
      m_base[k] = 0; m_size[k] = 0; m_esz[k] = 0; m_ev[k] = 16'hFFFF; m_oid[k] = 0;
      m_so[k] = 0; m_ho[k] = 0; m_si[k] = 0; m_hi[k] = 0; m_rep[k] = 0; m_err[k] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < NR; k++) begin
      look_ring = 2'(k); #1;
      chk(look_sw_occ == 0 && look_hw_occ == 0, "R1 occupancy at reset", look_sw_occ, 0);
      chk(look_sw_idx == 0 && look_hw_idx == 0, "R1 index at reset", look_hw_idx, 0);
    end
    chk(err == 0 && rsp_valid == 0, "R1 flags at reset", {err, rsp_valid}, 0);
    // R8 default event on a completion
    idle(); s_cmp_valid = 1; s_cmp_ring = 0; s_cmp_oid = 4'h5; tick(); idle(); tick();
    // R11 geometry, base words and address carry on ring 1, code 7, count 5
    cfg(1, 2, {1'b0, 3'd7, 8'd0, 20'd5});
    cfg(1, 0, 32'hFFFF_FFF0);
    cfg(1, 1, 32'h0000_0001);
    s_look = 1; tick();
    chk(look_sw_addr == 48'h1_FFFF_FFF0, "R11 base fields", look_sw_addr, 48'h1_FFFF_FFF0);
    for (int i = 0; i < 7; i++) begin
      s_cmp_valid = 1; s_cmp_ring = 1; tick();
    end
    idle(); s_look = 1; tick();
    chk(look_hw_idx == 2, "R5 wrap at count 5", look_hw_idx, 2);
    // R7 replace bit
    cfg(1, 4, 32'h19);
    s_cmp_valid = 1; s_cmp_ring = 1; s_cmp_oid = 4'h3; tick(); idle();
    chk(rsp_oid == 4'h9, "R7 replaced order id", rsp_oid, 9);
    // R4 underflow on ring 3
    s_look = 3; s_db_valid = 1; s_db_ring = 3; s_db_delta = 8'h80; tick(); idle();
    chk(err[3] == 1'b1 && look_sw_occ == 0, "R4 underflow clamp", {err[3], look_sw_occ}, 22'h200000);
    // R4 overflow clamp on ring 2
    s_look = 2; s_db_valid = 1; s_db_ring = 2; s_db_delta = 8'd127;
    for (int i = 0; i < 16520; i++) tick();
    idle();
    chk(look_sw_occ == 21'h1FFFFF && err[2], "R4 overflow clamp", look_sw_occ, 21'h1FFFFF);
    // R9 geometry write races a doorbell and completion on the same ring
    s_cfg_we = 1; s_cfg_ring = 2; s_cfg_sel = 3'd2; s_cfg_wdata = 32'd3;
    s_db_valid = 1; s_db_ring = 2; s_db_delta = 8'd9; s_cmp_valid = 1; s_cmp_ring = 2; tick(); idle();
    chk(look_sw_occ == 0 && look_hw_idx == 0 && look_hw_occ == 0, "R9 geometry clear",
        look_sw_occ, 0);
    // R10 stall: response held while not ready
    s_rsp_ready = 0; s_cmp_valid = 1; s_cmp_ring = 0; tick(); tick(); tick();
    chk(cmp_ready == 1'b0, "R10 completion stalled", cmp_ready, 0);
    idle(); tick();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      s_cfg_we = ($urandom % 16) == 0;
      s_cfg_ring = 2'($urandom); s_cfg_sel = 3'($urandom % 5);
      s_cfg_wdata = $urandom;
      if (s_cfg_sel == 3'd2 && ($urandom % 4) != 0)
        s_cfg_wdata = {1'b0, 3'($urandom), 8'd0, 20'(1 + $urandom % 12)};
      s_db_valid = $urandom % 2; s_db_ring = 2'($urandom);
      s_db_delta = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 8);
      s_cmp_valid = ($urandom % 5) < 2; s_cmp_ring = 2'($urandom); s_cmp_oid = 4'($urandom);
      s_ret_valid = ($urandom % 10) < 3; s_ret_ring = 2'($urandom);
      s_rsp_ready = ($urandom % 7) != 0; s_look = 2'($urandom);
      tick();
    end
    idle(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule